// File: doc/BRIEF.md
# Shared-Timebase Quad PWM Generator

This block produces four pulse-width-modulated waveforms from one common timebase. A prescaler divides the clock, and a single up-counter steps from zero to a programmable top value before it returns to zero. Every channel compares that shared count with its own threshold. So the waveform period is common to all four channels, and each channel sets only its own duty. Each channel drives a main pin and a complementary pin. Each pin has its own enable and its own inversion control. A global drive gate forces every pin to its idle level.

Software programs the block through a simple one-cycle write port. The top value and the thresholds can be written directly or through holding registers. When buffering is on, new values wait for the counter to return to zero, or for an explicit update strobe. This lets the period and duty change without a glitch while the waveform runs.

Top module: `shared_pwm_quad`

## Requirements
- R1: After a synchronous reset, all registers and the counter are zero, and every main pin and complementary pin is low.
- R2: Register 1 (PSC) and register 2 (TOP) shape the period. While the run bit (register 0, bit 0) is set, the counter advances once every PSC+1 clocks. It counts 0,1,…,TOP and then returns to 0, which gives a period of (TOP+1)·(PSC+1) clocks.
- R3: While the run bit is clear, the counter and the prescaler hold their values, and the pins do not change.
- R4: Registers 4+c hold the threshold for channel c. A channel's reference level is active while count < threshold. A threshold of 0 never makes the reference active. A threshold above TOP keeps it active for the whole period.
- R5: Register 3 holds a 4-bit slot per channel at bits c*4+3..c*4. Bit 0 is the main enable, bit 1 inverts the main pin, bit 2 is the complementary enable and bit 3 inverts the complementary pin. An enabled main pin equals reference XOR its invert bit. A disabled pin sits at its invert bit.
- R6: An enabled complementary pin equals NOT reference XOR its own invert bit.
- R7: While the drive bit (register 0, bit 3) is clear, every pin sits at its invert bit, whatever the count.
- R8: While the TOP buffering bit (register 0, bit 1) is clear, a TOP write takes effect on the next clock. While the threshold buffering bit (register 0, bit 2) is clear, a threshold write also takes effect on the next clock.
- R9: While a buffering bit is set, a write goes only to the holding register. The value it replaces stays in force until the clock on which the counter returns from TOP to 0.
- R10: A write to register 0 with bit 4 set is an update strobe. The bit is not stored. The strobe copies all holding registers into force, and clears the counter and the prescaler on that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Register index |
| wr_data | input | DW (16) | Write data |
| pwm_out | output | NCH (4) | Main pins, one per channel |
| pwm_out_n | output | NCH (4) | Complementary pins, one per channel |

## Verification
Every pin is a function of registered state only. A register write sampled at clock edge k therefore shows on the pins just after edge k. A counter step shows just after the edge on which the prescaler has reached PSC. The bench carries a behavioural model that applies the same edge rules. It compares both pin vectors at every falling edge, so each result is checked in the cycle it is due, and never at an edge where it changes. Inputs change one time unit after a falling edge, so the edge that samples them is unambiguous.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // Register indices of the write port
    localparam int REG_CTRL   = 0;
    localparam int REG_PRESC  = 1;
    localparam int REG_TOP    = 2;
    localparam int REG_OUTCFG = 3;
    localparam int REG_CMP0   = 4;

    // Bit of the control write that acts as the update strobe (not stored)
    localparam int UPD_BIT = 4;

    // Global control, bit 0 is run
    typedef struct packed {
        logic drive;     // bit 3
        logic cmp_buf;   // bit 2
        logic top_buf;   // bit 1
        logic run;       // bit 0
    } ctrl_t;

    // Per-channel output slot, bit 0 is main enable
    typedef struct packed {
        logic comp_inv;  // bit 3
        logic comp_en;   // bit 2
        logic main_inv;  // bit 1
        logic main_en;   // bit 0
    } chan_cfg_t;

    // Pin level: gated pins rest at their inversion bit
    function automatic logic pin_level(input logic lvl, input logic en,
                                       input logic inv, input logic drive);
        return (drive && en) ? (lvl ^ inv) : inv;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 16,
    parameter int PSC_W = 16,
    parameter int AW    = 3,
    parameter int DW    = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_addr,
    input  logic [DW-1:0]               wr_data,
    input  logic                        wrap,
    output ctrl_t                       ctrl,
    output logic [PSC_W-1:0]            psc,
    output logic [CNT_W-1:0]            top_act,
    output logic [NCH-1:0][CNT_W-1:0]   cmp_act,
    output chan_cfg_t [NCH-1:0]         cfg,
    output logic                        upd
);

    localparam int CFG_W = 4 * NCH;

    logic [CNT_W-1:0]             top_hold;
    logic [NCH-1:0][CNT_W-1:0]    cmp_hold;
    logic                         load;

    assign upd  = wr_en && (wr_addr == AW'(REG_CTRL)) && wr_data[UPD_BIT];
    assign load = upd || wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            psc      <= '0;
            top_hold <= '0;
            top_act  <= '0;
            cmp_hold <= '0;
            cmp_act  <= '0;
            cfg      <= '0;
        end else begin
            if (load) begin
                top_act <= top_hold;
                cmp_act <= cmp_hold;
            end
            if (wr_en) begin
                case (wr_addr)
                    AW'(REG_CTRL):   ctrl <= ctrl_t'(wr_data[3:0]);
                    AW'(REG_PRESC):  psc  <= wr_data[PSC_W-1:0];
                    AW'(REG_TOP): begin
                        top_hold <= wr_data[CNT_W-1:0];
                        if (!ctrl.top_buf) top_act <= wr_data[CNT_W-1:0];
                    end
                    AW'(REG_OUTCFG): cfg  <= wr_data[CFG_W-1:0];
                    default: ;
                endcase
                for (int c = 0; c < NCH; c++) begin
                    if (wr_addr == AW'(REG_CMP0 + c)) begin
                        cmp_hold[c] <= wr_data[CNT_W-1:0];
                        if (!ctrl.cmp_buf) cmp_act[c] <= wr_data[CNT_W-1:0];
                    end
                end
            end
        end
    end

    // R9: buffered thresholds stay in force until a load event
    assert_cmp_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl.cmp_buf && !load) |=> $stable(cmp_act));

    // R9: buffered top stays in force until a load event
    assert_top_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl.top_buf && !load) |=> $stable(top_act));

    // R8: unbuffered top write is in force one clock later
    assert_top_direct_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == AW'(REG_TOP) && !ctrl.top_buf)
        |=> top_act == $past(wr_data[CNT_W-1:0]));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              clr,
    input  logic [PSC_W-1:0]  psc,
    input  logic [CNT_W-1:0]  top,
    output logic [CNT_W-1:0]  cnt,
    output logic              wrap
);

    logic [PSC_W-1:0] pre;
    logic             tick;

    assign tick = run && (pre >= psc);
    assign wrap = tick && (cnt >= top);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre <= '0;
            cnt <= '0;
        end else if (tick) begin
            pre <= '0;
            cnt <= wrap ? '0 : cnt + 1'b1;
        end else if (run) begin
            pre <= pre + 1'b1;
        end
    end

    // R3: stopped timebase holds
    assert_freeze_R3: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr) |=> ($stable(cnt) && $stable(pre)));

    // R2: wrap returns to zero
    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (wrap && !clr) |=> cnt == '0);

    // R2: single step per prescaler expiry
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !wrap && !clr) |=> cnt == $past(cnt) + 1'b1);

    // R10: update strobe clears the timebase
    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0 && pre == '0));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  thr,
    input  chan_cfg_t         cfg,
    input  logic              drive,
    output logic              out,
    output logic              out_n
);

    logic ref_lvl;

    assign ref_lvl = cnt < thr;
    assign out     = pin_level(ref_lvl,  cfg.main_en, cfg.main_inv, drive);
    assign out_n   = pin_level(!ref_lvl, cfg.comp_en, cfg.comp_inv, drive);

    // R7: gated pins rest at their inversion bits
    assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !drive |-> (out == cfg.main_inv && out_n == cfg.comp_inv));

    // R4: zero threshold never activates the main pin
    assert_zero_thr_R4: assert property (@(posedge clk) disable iff (rst)
        (drive && cfg.main_en && thr == '0) |-> out == cfg.main_inv);

    // R6: both pins enabled means they are opposite before inversion
    assert_compl_R6: assert property (@(posedge clk) disable iff (rst)
        (drive && cfg.main_en && cfg.comp_en)
        |-> ((out ^ out_n) == !(cfg.main_inv ^ cfg.comp_inv)));

endmodule

// File: rtl/shared_pwm_quad.sv
module shared_pwm_quad
    import pwm_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 16,
    parameter int PSC_W = 16,
    parameter int DW    = 16,
    parameter int AW    = $clog2(REG_CMP0 + NCH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    output logic [NCH-1:0]  pwm_out,
    output logic [NCH-1:0]  pwm_out_n
);

    ctrl_t                      ctrl;
    logic [PSC_W-1:0]           psc;
    logic [CNT_W-1:0]           top_act;
    logic [NCH-1:0][CNT_W-1:0]  cmp_act;
    chan_cfg_t [NCH-1:0]        cfg;
    logic                       upd;
    logic [CNT_W-1:0]           cnt;
    logic                       wrap;

    pwm_regs #(.NCH(NCH), .CNT_W(CNT_W), .PSC_W(PSC_W), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wrap(wrap), .ctrl(ctrl), .psc(psc), .top_act(top_act),
        .cmp_act(cmp_act), .cfg(cfg), .upd(upd)
    );

    pwm_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
        .clk(clk), .rst(rst), .run(ctrl.run), .clr(upd), .psc(psc),
        .top(top_act), .cnt(cnt), .wrap(wrap)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst(rst), .cnt(cnt), .thr(cmp_act[c]), .cfg(cfg[c]),
            .drive(ctrl.drive), .out(pwm_out[c]), .out_n(pwm_out_n[c])
        );
    end

    // R1: pins are low on the clock after reset
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (pwm_out == '0 && pwm_out_n == '0));

endmodule

// File: tb/shared_pwm_quad_tb.sv
module shared_pwm_quad_tb;

    localparam int NCH = 4;

    logic           clk = 0;
    logic           rst = 1;
    logic           wr_en = 0;
    logic [2:0]     wr_addr = '0;
    logic [15:0]    wr_data = '0;
    logic [NCH-1:0] pwm_out, pwm_out_n;

    shared_pwm_quad u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .pwm_out_n(pwm_out_n)
    );

    always #5 clk = ~clk;

    int compared = 0, mismatched = 0, cyc = 0;
    bit armed = 0, done = 0;
    string tag = "R1";

    // behavioural model state
    int m_ctrl, m_psc, m_top_h, m_top, m_cfg, m_pre, m_cnt;
    int m_cmp_h[NCH], m_cmp[NCH];

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 0; m_psc = 0; m_top_h = 0; m_top = 0; m_cfg = 0;
            m_pre = 0; m_cnt = 0;
            for (int c = 0; c < NCH; c++) begin m_cmp_h[c] = 0; m_cmp[c] = 0; end
        end else begin
            bit strobe, run, step, roll;
            int n_top, n_pre, n_cnt;
            int n_cmp[NCH];
            strobe = wr_en && wr_addr == 0 && wr_data[4];
            run  = m_ctrl[0];
            step = run && m_pre >= m_psc;
            roll = step && m_cnt >= m_top;
            n_pre = m_pre; n_cnt = m_cnt; n_top = m_top;
            for (int c = 0; c < NCH; c++) n_cmp[c] = m_cmp[c];
            if (strobe) begin n_pre = 0; n_cnt = 0; end
            else if (step) begin n_pre = 0; n_cnt = roll ? 0 : m_cnt + 1; end
            else if (run) n_pre = m_pre + 1;
            if (strobe || roll) begin
                n_top = m_top_h;
                for (int c = 0; c < NCH; c++) n_cmp[c] = m_cmp_h[c];
            end
            if (wr_en) begin
                int d;
                d = int'(wr_data);
                if (wr_addr == 0) m_ctrl = d & 15;
                else if (wr_addr == 1) m_psc = d;
                else if (wr_addr == 3) m_cfg = d;
                else if (wr_addr == 2) begin
                    if (!m_ctrl[1]) n_top = d;
                    m_top_h = d;
                end else begin
                    if (!m_ctrl[2]) n_cmp[wr_addr-4] = d;
                    m_cmp_h[wr_addr-4] = d;
                end
            end
            m_pre = n_pre; m_cnt = n_cnt; m_top = n_top;
            for (int c = 0; c < NCH; c++) m_cmp[c] = n_cmp[c];
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (armed && !done) begin
            logic [NCH-1:0] e_out, e_n;
            for (int c = 0; c < NCH; c++) begin
                bit r, g;
                r = m_cnt < m_cmp[c];
                g = m_ctrl[3];
                e_out[c] = (g && m_cfg[c*4])   ? (r ^ m_cfg[c*4+1])  : m_cfg[c*4+1];
                e_n[c]   = (g && m_cfg[c*4+2]) ? (!r ^ m_cfg[c*4+3]) : m_cfg[c*4+3];
            end
            compared++;
            if (pwm_out !== e_out || pwm_out_n !== e_n) begin
                mismatched++;
                $display("FAIL %s cycle %0d: out=%b/%b expected %b/%b",
                         tag, cyc, pwm_out, pwm_out_n, e_out, e_n);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 100000 && !done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk); #1;
        wr_en = 1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk); #1;
        wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        @(posedge clk); armed = 1;
        idle(2);
        // R1: explicit reset-state check
        compared++;
        if (pwm_out !== '0 || pwm_out_n !== '0) begin
            mismatched++;
            $display("FAIL R1 reset: out=%b/%b expected 0000/0000", pwm_out, pwm_out_n);
        end
        #1 rst = 0;

        // R4/R2: thresholds 3, 0, above top, 5; top 9, prescale 1
        tag = "R4";
        wr(1, 1); wr(2, 9);
        wr(4, 3); wr(5, 0); wr(6, 12); wr(7, 5);
        wr(3, 16'h1111);
        wr(0, 4'b1001);
        idle(60);
        tag = "R2"; wr(1, 0); idle(30); wr(1, 3); idle(90); wr(1, 1);

        // R5: inversion on channels 1 and 2, channel 3 main disabled
        tag = "R5"; wr(3, 16'h0631); idle(40);
        // R6: complementary pins, mixed inversion
        tag = "R6"; wr(3, 16'hC5F5); idle(40);
        // R7: drive gate off
        tag = "R7"; wr(0, 4'b0001); idle(25); wr(0, 4'b1001);
        // R3: run cleared with drive on
        tag = "R3"; wr(0, 4'b1000); idle(25); wr(0, 4'b1001);

        // R9: buffered thresholds and top, written mid-period
        tag = "R9"; wr(0, 4'b1111); idle(5);
        wr(4, 8); wr(2, 5); idle(3); wr(7, 1); idle(60);

        // R10: update strobe while buffering
        tag = "R10"; wr(2, 15); wr(4, 2); idle(2);
        wr(0, 16'h001F); idle(50);

        // R8: direct writes take effect at once
        tag = "R8"; wr(0, 4'b1001); idle(7);
        wr(2, 4); wr(5, 3); idle(30); wr(2, 11); wr(6, 6); idle(40);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule